// File: doc/BRIEF.md
# Probe Filter Home Controller

This block is the coherence controller that sits at the home node of a four-node shared-memory system. Remote nodes send it read requests for lines whose home is this node. For each request it looks up a small set-associative directory before any probe goes out. The directory records, for each tracked line, which node last took the line and whether that node holds it as the single owner or as a sharer.

When the directory names a remote owner, the controller sends one directed probe to that owner only. The owner then passes the data straight to the requester, so the transaction needs a request, a probe, an acknowledgement and one data message. A directory miss means no other node caches the line. The line is then served from memory and a directory entry is allocated for the requester. If that allocation displaces a valid entry, an invalidate probe goes to the displaced line's recorded node first.

A configuration input turns the filter off. With the filter off, every request falls back to broadcast probing of all non-home nodes, and the controller waits for every response. This mode suits systems with only two nodes, where a broadcast reaches the same single peer as a directed probe. Only one transaction is in flight at a time, and the request port applies ready/valid backpressure while one is open.

Top module: `probe_filter_home`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `prb_valid`, `mem_valid` and `cpl_valid` are 0, and every directory entry is invalid, so the first request to any line is a miss. No probe is ever addressed to the home node (`HOME_ID`, default 0); bit n of `prb_mask` addresses node n.
- R2: With the filter enabled, a request that misses the set whose index is the low `SET_BITS` bits of `req_addr`, and that finds an invalid way in that set, sends no probe. It produces one `mem_valid` pulse carrying the request address and `mem_node` equal to the requester. It then records the line as owned by the requester.
- R3: With the filter enabled, a hit on a line owned by a node other than the requester sends exactly one probe. That probe has a one-hot `prb_mask` naming the owner, `prb_inv` = 0, `prb_addr` equal to the line and `prb_req_node` equal to the requester. No memory read follows. After the owner's response, the line is recorded as shared with the requester as its last holder.
- R4: With the filter enabled, a hit on a shared line, or on a line owned by the requester itself, sends no probe and produces one memory read to the requester.
- R5: The victim is the lowest-numbered invalid way. If all four ways are valid, a three-bit tree chooses the victim. Root bit 0 picks ways 0-1 when 0 and ways 2-3 when 1. Bit 1 picks way 0 when 0 and way 1 when 1. Bit 2 picks way 2 when 0 and way 3 when 1. Every hit or allocation turns the bits on the way's path to point away from it.
- R6: Displacing a valid entry sends a single invalidate probe (`prb_inv` = 1) to the recorded node, with `prb_addr` equal to the displaced line. The memory read for the new line appears only after that node's response.
- R7: With `cfg_filter_en` = 0, a request probes all non-home nodes in one `prb_mask` and waits for a response from each of them. It issues a memory read only if no response had `rsp_fwd` set, and it leaves the directory unchanged.
- R8: From the cycle after a request is accepted until its completion pulse, `req_ready` is 0.
- R9: Each accepted request produces exactly one single-cycle `cpl_valid` pulse. The pulse comes after the last awaited probe response, in the same cycle as any memory read for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_filter_en | input | 1 | 1 = directory lookup, 0 = broadcast probing |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_node | input | 2 | Requesting node ID |
| req_addr | input | ADDR_W | Line address requested |
| prb_valid | output | 1 | Probe issued this cycle |
| prb_mask | output | 4 | Destination nodes of the probe, one bit per node |
| prb_inv | output | 1 | 1 = invalidate probe, 0 = forward-to-requester probe |
| prb_addr | output | ADDR_W | Line address of the probe |
| prb_req_node | output | 2 | Node the data should be forwarded to |
| rsp_valid | input | 1 | Probe response present |
| rsp_node | input | 2 | Node giving the response |
| rsp_fwd | input | 1 | Responder forwarded the data itself |
| mem_valid | output | 1 | Memory read issued this cycle |
| mem_addr | output | ADDR_W | Line address to read |
| mem_node | output | 2 | Node that receives the memory data |
| cpl_valid | output | 1 | Transaction finished this cycle |

## Verification
The assertions assume that requests only come from remote nodes, never from the home node. They also assume that `cfg_filter_en` holds steady while a request is looked up, and that responses only come from nodes that were probed. The bench keeps within these bounds. Every request uses node 1, 2 or 3, and the configuration bit changes only while the controller is idle. The bench answers only the nodes named in the last `prb_mask`, one per cycle, starting from the lowest. The assertion that memory reads never target the home node therefore reflects the request stream rather than anything the controller enforces.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int NODE_W = 2;
    localparam int NODES  = 1 << NODE_W;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int PLRU_W = WAYS - 1;

    typedef enum logic [1:0] {
        DS_UNCACHED = 2'd0,
        DS_SHARED   = 2'd1,
        DS_OWNED    = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic                valid;
        dir_state_e          state;
        logic [NODE_W-1:0]   owner;
    } dir_meta_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LOOK = 2'd1,
        FS_WAIT = 2'd2
    } fsm_e;

    typedef enum logic [1:0] {
        WK_DIRECT = 2'd0,
        WK_EVICT  = 2'd1,
        WK_BCAST  = 2'd2
    } wait_kind_e;

    function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] id);
        logic [NODES-1:0] r;
        r     = '0;
        r[id] = 1'b1;
        return r;
    endfunction

    // Tree walk: root selects half, leaf bit selects way within the half.
    function automatic logic [WAY_W-1:0] plru_pick(input logic [PLRU_W-1:0] b);
        if (!b[0]) return b[1] ? 2'd1 : 2'd0;
        else       return b[2] ? 2'd3 : 2'd2;
    endfunction

    // Point every bit on the touched way's path away from it.
    function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] b,
                                                     input logic [WAY_W-1:0]  way);
        logic [PLRU_W-1:0] r;
        r = b;
        if (!way[1]) begin
            r[0] = 1'b1;
            r[1] = ~way[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~way[0];
        end
        return r;
    endfunction
endpackage

// File: rtl/pf_dir_array.sv
module pf_dir_array
    import pf_pkg::*;
#(
    parameter int TAG_W    = 14,
    parameter int SET_BITS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SET_BITS-1:0]           rd_set,
    input  logic [TAG_W-1:0]              rd_tag,
    output logic                          hit,
    output logic [WAY_W-1:0]              hit_way,
    output dir_meta_t [WAYS-1:0]          set_meta,
    output logic [WAYS-1:0][TAG_W-1:0]    set_tags,
    input  logic                          wr_en,
    input  logic [SET_BITS-1:0]           wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  dir_meta_t                     wr_meta
);
    localparam int SETS = 1 << SET_BITS;

    dir_meta_t        meta_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [WAYS-1:0]  way_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    meta_q[s][w] <= '0;
        end else if (wr_en) begin
            meta_q[wr_set][wr_way] <= wr_meta;
            tag_q[wr_set][wr_way]  <= wr_tag;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_meta[w] = meta_q[rd_set][w];
        assign set_tags[w] = tag_q[rd_set][w];
        assign way_hit[w]  = meta_q[rd_set][w].valid && (tag_q[rd_set][w] == rd_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (way_hit[w]) hit_way = WAY_W'(w);
    end
    assign hit = |way_hit;
endmodule

// File: rtl/pf_plru.sv
module pf_plru
    import pf_pkg::*;
#(
    parameter int SET_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SET_BITS-1:0]  sel_set,
    input  logic [WAYS-1:0]      way_valid,
    output logic [WAY_W-1:0]     victim_way,
    input  logic                 touch_en,
    input  logic [SET_BITS-1:0]  touch_set,
    input  logic [WAY_W-1:0]     touch_way
);
    localparam int SETS = 1 << SET_BITS;

    logic [PLRU_W-1:0] bits_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
        end else if (touch_en) begin
            bits_q[touch_set] <= plru_touch(bits_q[touch_set], touch_way);
        end
    end

    always_comb begin
        victim_way = plru_pick(bits_q[sel_set]);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!way_valid[w]) victim_way = WAY_W'(w);
    end
endmodule

// File: rtl/probe_filter_home.sv
module probe_filter_home
    import pf_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                SET_BITS = 2,
    parameter logic [NODE_W-1:0] HOME_ID  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_filter_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NODE_W-1:0] req_node,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              prb_valid,
    output logic [NODES-1:0]  prb_mask,
    output logic              prb_inv,
    output logic [ADDR_W-1:0] prb_addr,
    output logic [NODE_W-1:0] prb_req_node,
    input  logic              rsp_valid,
    input  logic [NODE_W-1:0] rsp_node,
    input  logic              rsp_fwd,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NODE_W-1:0] mem_node,
    output logic              cpl_valid
);
    localparam int               TAG_W  = ADDR_W - SET_BITS;
    localparam logic [NODES-1:0] OTHERS = ~node_bit(HOME_ID);

    fsm_e              state_q, state_d;
    wait_kind_e        kind_q, kind_d;
    logic [ADDR_W-1:0] addr_q;
    logic [NODE_W-1:0] node_q;
    logic [WAY_W-1:0]  way_q, way_d;
    logic [NODES-1:0]  pend_q, pend_d, rsp_bit, pend_left;
    logic              fwd_q, fwd_d, fwd_now;

    logic [SET_BITS-1:0]        cur_set;
    logic [TAG_W-1:0]           cur_tag;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way, vic_way;
    dir_meta_t [WAYS-1:0]       set_meta;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            way_valid;
    dir_meta_t                  hm, vm, wr_meta;
    logic                       wr_en, touch_en;
    logic [WAY_W-1:0]           wr_way, touch_way;

    logic              e_prb, e_inv, e_mem, e_cpl;
    logic [NODES-1:0]  e_mask;
    logic [ADDR_W-1:0] e_paddr;

    assign cur_set = addr_q[SET_BITS-1:0];
    assign cur_tag = addr_q[ADDR_W-1:SET_BITS];

    pf_dir_array #(.TAG_W(TAG_W), .SET_BITS(SET_BITS)) u_dir (
        .clk(clk), .rst(rst), .rd_set(cur_set), .rd_tag(cur_tag),
        .hit(hit), .hit_way(hit_way), .set_meta(set_meta), .set_tags(set_tags),
        .wr_en(wr_en), .wr_set(cur_set), .wr_way(wr_way), .wr_tag(cur_tag),
        .wr_meta(wr_meta)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_vld
        assign way_valid[w] = set_meta[w].valid;
    end

    pf_plru #(.SET_BITS(SET_BITS)) u_plru (
        .clk(clk), .rst(rst), .sel_set(cur_set), .way_valid(way_valid),
        .victim_way(vic_way), .touch_en(touch_en), .touch_set(cur_set),
        .touch_way(touch_way)
    );

    assign hm        = set_meta[hit_way];
    assign vm        = set_meta[vic_way];
    assign rsp_bit   = (rsp_valid && state_q == FS_WAIT) ? (node_bit(rsp_node) & pend_q) : '0;
    assign pend_left = pend_q & ~rsp_bit;
    assign fwd_now   = fwd_q | (rsp_fwd && (|rsp_bit));
    assign req_ready = (state_q == FS_IDLE);

    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        way_d     = way_q;
        pend_d    = pend_left;
        fwd_d     = fwd_now;
        wr_en     = 1'b0;
        wr_way    = way_q;
        wr_meta   = '0;
        touch_en  = 1'b0;
        touch_way = way_q;
        e_prb     = 1'b0;
        e_inv     = 1'b0;
        e_mask    = '0;
        e_paddr   = addr_q;
        e_mem     = 1'b0;
        e_cpl     = 1'b0;
        case (state_q)
            FS_IDLE: if (req_valid) begin
                state_d = FS_LOOK;
                pend_d  = '0;
                fwd_d   = 1'b0;
            end
            FS_LOOK: begin
                if (!cfg_filter_en) begin
                    e_prb   = 1'b1;
                    e_mask  = OTHERS;
                    pend_d  = OTHERS;
                    kind_d  = WK_BCAST;
                    state_d = FS_WAIT;
                end else if (hit) begin
                    touch_en  = 1'b1;
                    touch_way = hit_way;
                    way_d     = hit_way;
                    if (hm.state == DS_OWNED && hm.owner != node_q) begin
                        e_prb   = 1'b1;
                        e_mask  = node_bit(hm.owner);
                        pend_d  = node_bit(hm.owner);
                        kind_d  = WK_DIRECT;
                        state_d = FS_WAIT;
                    end else begin
                        e_mem   = 1'b1;
                        e_cpl   = 1'b1;
                        wr_en   = 1'b1;
                        wr_way  = hit_way;
                        wr_meta = '{valid: 1'b1, state: hm.state, owner: node_q};
                        state_d = FS_IDLE;
                    end
                end else begin
                    way_d = vic_way;
                    if (vm.valid) begin
                        e_prb   = 1'b1;
                        e_inv   = 1'b1;
                        e_mask  = node_bit(vm.owner);
                        e_paddr = {set_tags[vic_way], cur_set};
                        pend_d  = node_bit(vm.owner);
                        kind_d  = WK_EVICT;
                        state_d = FS_WAIT;
                    end else begin
                        e_mem     = 1'b1;
                        e_cpl     = 1'b1;
                        wr_en     = 1'b1;
                        wr_way    = vic_way;
                        wr_meta   = '{valid: 1'b1, state: DS_OWNED, owner: node_q};
                        touch_en  = 1'b1;
                        touch_way = vic_way;
                        state_d   = FS_IDLE;
                    end
                end
            end
            FS_WAIT: if (pend_left == '0) begin
                state_d = FS_IDLE;
                e_cpl   = 1'b1;
                case (kind_q)
                    WK_DIRECT: begin
                        wr_en   = 1'b1;
                        wr_meta = '{valid: 1'b1, state: DS_SHARED, owner: node_q};
                    end
                    WK_EVICT: begin
                        e_mem    = 1'b1;
                        wr_en    = 1'b1;
                        wr_meta  = '{valid: 1'b1, state: DS_OWNED, owner: node_q};
                        touch_en = 1'b1;
                    end
                    default: e_mem = !fwd_now;
                endcase
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FS_IDLE;
            kind_q    <= WK_BCAST;
            addr_q    <= '0;
            node_q    <= '0;
            way_q     <= '0;
            pend_q    <= '0;
            fwd_q     <= 1'b0;
            prb_valid <= 1'b0;
            prb_mask  <= '0;
            prb_inv   <= 1'b0;
            prb_addr  <= '0;
            prb_req_node <= '0;
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_node  <= '0;
            cpl_valid <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            way_q   <= way_d;
            pend_q  <= pend_d;
            fwd_q   <= fwd_d;
            if (state_q == FS_IDLE && req_valid) begin
                addr_q <= req_addr;
                node_q <= req_node;
            end
            prb_valid <= e_prb;
            if (e_prb) begin
                prb_mask     <= e_mask;
                prb_inv      <= e_inv;
                prb_addr     <= e_paddr;
                prb_req_node <= node_q;
            end
            mem_valid <= e_mem;
            if (e_mem) begin
                mem_addr <= addr_q;
                mem_node <= node_q;
            end
            cpl_valid <= e_cpl;
        end
    end
endmodule

// File: rtl/pf_home_checks.sv
module pf_home_checks
    import pf_pkg::*;
#(
    parameter logic [NODE_W-1:0] HOME_ID = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_filter_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic              prb_valid,
    input logic [NODES-1:0]  prb_mask,
    input logic              mem_valid,
    input logic [NODE_W-1:0] mem_node,
    input logic              cpl_valid
);
    localparam logic [NODES-1:0] OTHERS = ~node_bit(HOME_ID);

    a_r1_home_never_probed: assert property (@(posedge clk) disable iff (rst)
        prb_valid |-> !prb_mask[HOME_ID]);

    a_r2_mem_to_remote: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_node != HOME_ID));

    a_r3_single_target: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && $past(cfg_filter_en)) |-> $onehot(prb_mask));

    a_r6_probe_before_read: assert property (@(posedge clk) disable iff (rst)
        prb_valid |-> (!mem_valid && !cpl_valid));

    a_r7_broadcast_all: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && !$past(cfg_filter_en)) |-> (prb_mask == OTHERS));

    a_r8_busy_backpressure: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_cpl_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> !cpl_valid);
endmodule

bind probe_filter_home pf_home_checks #(.HOME_ID(HOME_ID)) u_checks (
    .clk(clk), .rst(rst), .cfg_filter_en(cfg_filter_en), .req_valid(req_valid),
    .req_ready(req_ready), .prb_valid(prb_valid), .prb_mask(prb_mask),
    .mem_valid(mem_valid), .mem_node(mem_node), .cpl_valid(cpl_valid)
);

// File: tb/probe_filter_home_tb.sv
`timescale 1ns/1ps
module probe_filter_home_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_filter_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_node = '0;
    logic [15:0] req_addr = '0;
    logic        prb_valid, prb_inv;
    logic [3:0]  prb_mask;
    logic [15:0] prb_addr;
    logic [1:0]  prb_req_node;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_node = '0;
    logic        rsp_fwd = 1'b0;
    logic        mem_valid, cpl_valid;
    logic [15:0] mem_addr;
    logic [1:0]  mem_node;

    int checks = 0;
    int errors = 0;

    probe_filter_home u_dut (
        .clk(clk), .rst(rst), .cfg_filter_en(cfg_filter_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
        .req_addr(req_addr), .prb_valid(prb_valid), .prb_mask(prb_mask),
        .prb_inv(prb_inv), .prb_addr(prb_addr), .prb_req_node(prb_req_node),
        .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_fwd(rsp_fwd),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_node(mem_node),
        .cpl_valid(cpl_valid)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic        en;
        logic [1:0]  nd;
        logic [15:0] ad;
        logic [1:0]  fw;
        logic [3:0]  mk;
        logic        inv;
        logic [15:0] pa;
        logic        mem;
        logic [3:0]  rq;
    } vec_t;

    // Set 0 lines: A=0000 B=0004 C=0008 D=000C E=0010. Home is node 0.
    localparam vec_t VECS [15] = '{
        '{1'b1, 2'd1, 16'h0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 1'b1, 4'd2}, // R2 A miss
        '{1'b1, 2'd2, 16'h0000, 2'd0, 4'b0010, 1'b0, 16'h0000, 1'b0, 4'd3}, // R3 A owned by 1
        '{1'b1, 2'd3, 16'h0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 1'b1, 4'd4}, // R4 A shared
        '{1'b1, 2'd1, 16'h0004, 2'd0, 4'b0000, 1'b0, 16'h0004, 1'b1, 4'd2}, // R2 B miss
        '{1'b1, 2'd1, 16'h0004, 2'd0, 4'b0000, 1'b0, 16'h0004, 1'b1, 4'd4}, // R4 B owned by self
        '{1'b1, 2'd2, 16'h0008, 2'd0, 4'b0000, 1'b0, 16'h0008, 1'b1, 4'd2}, // R2 C miss
        '{1'b1, 2'd3, 16'h000C, 2'd0, 4'b0000, 1'b0, 16'h000C, 1'b1, 4'd2}, // R2 D miss, set full
        '{1'b1, 2'd2, 16'h0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 1'b1, 4'd4}, // R4 A hit, tree touch
        '{1'b1, 2'd1, 16'h0010, 2'd0, 4'b0100, 1'b1, 16'h0008, 1'b1, 4'd6}, // R6 R5 E evicts C
        '{1'b1, 2'd3, 16'h0008, 2'd0, 4'b0010, 1'b1, 16'h0004, 1'b1, 4'd5}, // R5 R6 C evicts B
        '{1'b0, 2'd2, 16'h0000, 2'd0, 4'b1110, 1'b0, 16'h0000, 1'b1, 4'd7}, // R7 broadcast
        '{1'b0, 2'd3, 16'h000C, 2'd1, 4'b1110, 1'b0, 16'h000C, 1'b0, 4'd7}, // R7 node 1 forwards
        '{1'b1, 2'd1, 16'h0000, 2'd0, 4'b0000, 1'b0, 16'h0000, 1'b1, 4'd7}, // R7 dir untouched
        '{1'b1, 2'd2, 16'h0010, 2'd0, 4'b0010, 1'b0, 16'h0010, 1'b0, 4'd3}, // R3 E owned by 1
        '{1'b1, 2'd3, 16'h000C, 2'd0, 4'b0000, 1'b0, 16'h000C, 1'b1, 4'd4}  // R4 D owned by self
    };

    int          o_prb, o_rsp, o_mem, o_cpl, o_busy;
    logic [3:0]  o_mask;
    logic        o_inv;
    logic [15:0] o_paddr, o_maddr;
    logic [1:0]  o_preq, o_mnode;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic en, input logic [1:0] nd, input logic [15:0] ad,
                           input logic [1:0] fwn);
        logic [3:0] pend;
        bit done;
        @(negedge clk);
        cfg_filter_en = en;
        req_valid = 1'b1;
        req_node = nd;
        req_addr = ad;
        @(negedge clk);
        req_valid = 1'b0;
        o_prb = 0; o_rsp = 0; o_mem = 0; o_cpl = 0; o_busy = 0;
        o_mask = '0; o_inv = 1'b0; o_paddr = '0; o_preq = '0; o_maddr = '0; o_mnode = '0;
        pend = '0;
        done = 1'b0;
        for (int c = 0; c < 40 && !done; c++) begin
            rsp_valid = 1'b0;
            rsp_fwd = 1'b0;
            if (prb_valid) begin
                o_prb++;
                o_mask = prb_mask; o_inv = prb_inv; o_paddr = prb_addr; o_preq = prb_req_node;
                pend = pend | prb_mask;
            end
            if (mem_valid) begin
                o_mem++; o_maddr = mem_addr; o_mnode = mem_node;
            end
            if (cpl_valid) begin
                o_cpl++; done = 1'b1;
            end else if (req_ready) begin
                o_busy++;
            end
            if (!done && pend != '0) begin
                bit picked;
                picked = 1'b0;
                for (int n = 0; n < 4; n++) begin
                    if (pend[n] && !picked) begin
                        picked = 1'b1;
                        rsp_valid = 1'b1;
                        rsp_node = 2'(n);
                        rsp_fwd = (2'(n) == fwn);
                        pend[n] = 1'b0;
                        o_rsp++;
                    end
                end
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        rsp_fwd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        chk("R1", "prb_valid after reset", int'(prb_valid), 0);
        chk("R1", "mem_valid after reset", int'(mem_valid), 0);
        chk("R1", "cpl_valid after reset", int'(cpl_valid), 0);

        foreach (VECS[i]) begin
            string tag;
            vec_t v;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.rq, i);
            run_txn(v.en, v.nd, v.ad, v.fw);
            chk(tag, "probe count", o_prb, (v.mk != '0) ? 1 : 0);
            chk(tag, "probe mask", int'(o_mask), int'(v.mk));
            // R3 R7 one response per probed node
            chk(tag, "responses", o_rsp, $countones(v.mk));
            if (v.mk != '0) begin
                chk(tag, "probe kind", int'(o_inv), int'(v.inv));
                chk(tag, "probe addr", int'(o_paddr), int'(v.pa));
                chk(tag, "probe requester", int'(o_preq), int'(v.nd));
            end
            chk(tag, "memory reads", o_mem, int'(v.mem));
            if (v.mem) begin
                chk(tag, "memory addr", int'(o_maddr), int'(v.ad));
                chk(tag, "memory node", int'(o_mnode), int'(v.nd));
            end
            chk("R9", "completion pulses", o_cpl, 1);
            chk("R8", "ready while busy", o_busy, 0);
        end

        // R1 mid-run reset clears the directory: A misses again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "req_ready after second reset", int'(req_ready), 1);
        run_txn(1'b1, 2'd2, 16'h0000, 2'd0);
        chk("R1", "no probe after reset", o_prb, 0);
        chk("R1", "memory read after reset", o_mem, 1);

        // R2 R3 new allocation records node 2, then node 3 gets a directed probe
        run_txn(1'b1, 2'd3, 16'h0000, 2'd0);
        chk("R3", "directed probe mask after realloc", int'(o_mask), 4'b0100);
        chk("R3", "no memory read on directed probe", o_mem, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule